// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the 32-bit datapath of a small sequenced processor. Every register transfer passes over one shared internal bus. The sources that can drive the bus are the register RAM, the ALU, memory read data and the immediate generator. The destinations that can load from it are the register RAM, the two ALU operand latches, the memory-address register, the instruction register and the memory write port. The register RAM holds the 32 integer registers plus the program counter, which sits at entry 32.

An external sequencer drives one set of control strobes per clock. Each set makes one transfer: it enables a single bus source and raises the load strobes of one or more destinations, and the transfer completes at the next clock edge. The block hands back what the sequencer needs to choose its next step:

- the opcode field of the instruction register,
- a condition flag computed from the ALU result,
- the memory busy flag.

Top module: `sbus_datapath`

## Requirements
- R1: After reset (active-low `rst_n`) the operand latches, the memory-address register and the instruction register hold zero, so `mem_addr_o` and `opcode_o` read 0 and an ADD driven by the ALU places 0 on the bus.
- R2: At most one source enable (`reg_drv_i`, `alu_drv_i`, `mem_drv_i`, `imm_drv_i`) is active in a cycle. `bus_o` equals the value of the enabled source in that same cycle, and reads 0 when no source is enabled.
- R3: `rsel_i` picks the register index: 0 selects the program counter (entry 32), 1 selects IR[19:15], 2 selects IR[24:20] and 3 selects IR[11:7]. With `reg_wr_i` high, the bus value is written at the clock edge, and it can be read back in any later cycle with `reg_drv_i`.
- R4: Register x0 always reads as zero, and writes to x0 are discarded.
- R5: The program counter entry is separate from x1–x31. Writing x31 leaves the program counter unchanged, and writing the program counter leaves x31 unchanged.
- R6: `a_ld_i` and `b_ld_i` load latch A and latch B from the bus at the clock edge. A latch whose load strobe is low keeps its value.
- R7: With `alu_drv_i` high, the bus carries `alu_op_i`(A,B) under this encoding:
  - 0: add
  - 1: subtract A−B
  - 2: signed less-than
  - 3: unsigned less-than
  - 4: equal
  - 5: not equal
  - 6: AND
  - 7: OR

  The compare operations give 0 or 1.
- R8: `cond_o` is 1 exactly when the ALU result for the current `alu_op_i`, A and B is nonzero, whether or not the ALU drives the bus.
- R9: `mar_ld_i` loads the memory-address register from the bus, and `mem_addr_o` shows it from the next cycle. `mem_we_o` follows `mem_wr_i`, `mem_wdata_o` carries the bus, `mem_re_o` follows `mem_drv_i`, and `busy_o` follows `mem_busy_i`.
- R10: `ir_ld_i` loads the instruction register from the bus, and `opcode_o` shows IR[6:0] from the next cycle. Without `ir_ld_i` the register holds its value.
- R11: With `imm_drv_i` high, the bus carries a sign-extended immediate chosen by `imm_fmt_i`:
  - 0 (I format): IR[31:20].
  - 1 (J format): {IR[31], IR[19:12], IR[20], IR[30:21], 0}.
  - 2 (B format): {IR[31], IR[7], IR[30:25], IR[11:8], 0}.
  - 3 (S format): {IR[31:25], IR[11:7]}.
- R12: An ALU result can be written back to a register in the same cycle it is driven, and latches can be loaded from a register read in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsel_i | input | 2 | Register index select (PC, rs1, rs2, rd) |
| reg_wr_i | input | 1 | Write bus into selected register |
| reg_drv_i | input | 1 | Drive selected register onto bus |
| a_ld_i | input | 1 | Load latch A from bus |
| b_ld_i | input | 1 | Load latch B from bus |
| alu_op_i | input | 3 | ALU operation code |
| alu_drv_i | input | 1 | Drive ALU result onto bus |
| mar_ld_i | input | 1 | Load memory-address register from bus |
| mem_drv_i | input | 1 | Drive memory read data onto bus |
| mem_wr_i | input | 1 | Write bus data to memory |
| ir_ld_i | input | 1 | Load instruction register from bus |
| imm_drv_i | input | 1 | Drive immediate onto bus |
| imm_fmt_i | input | 2 | Immediate format select |
| mem_rdata_i | input | 32 | Memory read data |
| mem_busy_i | input | 1 | Memory busy flag |
| mem_addr_o | output | 32 | Memory address (MAR) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| busy_o | output | 1 | Busy flag to sequencer |
| opcode_o | output | 7 | Instruction opcode field |
| cond_o | output | 1 | ALU result nonzero |
| bus_o | output | 32 | Shared bus value |

## Verification
The ALU is tried with two operand pairs. A negative operand against a small positive one makes the signed and unsigned less-than results disagree and gives different answers for AND and OR. Equal operands flip the equal and not-equal results, along with `cond_o`.

Register traffic is run through each of the four index sources. A write to x31 and a write to the program counter are interleaved, so a collision between entry 32 and entry 31 would show up. The immediate formats are tried on an instruction word with the sign bit set and mixed field bits, so any misplaced bit in a format shows up.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int XLEN = 32;
    localparam int NXREG = 32;
    localparam int PC_IDX = NXREG;
    localparam int IDXW = $clog2(NXREG + 1);

    typedef enum logic [1:0] {
        RS_PC  = 2'd0,
        RS_RS1 = 2'd1,
        RS_RS2 = 2'd2,
        RS_RD  = 2'd3
    } rsel_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_SLT  = 3'd2,
        OP_SLTU = 3'd3,
        OP_EQ   = 3'd4,
        OP_NE   = 3'd5,
        OP_AND  = 3'd6,
        OP_OR   = 3'd7
    } aluop_e;

    typedef enum logic [1:0] {
        IMM_I = 2'd0,
        IMM_J = 2'd1,
        IMM_B = 2'd2,
        IMM_S = 2'd3
    } immfmt_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] mar;
        logic [31:0]     ir;
    } dp_state_t;
endpackage

// File: rtl/sbus_regram.sv
module sbus_regram
    import sbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] idx_i,
    input  logic            we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] rdata_o
);
    localparam int DEPTH = NXREG + 1;

    logic [XLEN-1:0] ram_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i && (idx_i != '0)) begin
            ram_q[idx_i] <= wdata_i;
        end
    end

    always_comb begin
        if (idx_i == '0) begin
            rdata_o = '0;
        end else begin
            rdata_o = ram_q[idx_i];
        end
    end

    AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_i == '0) |-> (rdata_o == '0)); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i != '0) |=> (ram_q[$past(idx_i)] == $past(wdata_i))); // R3
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    always_comb begin
        res_o = '0;
        unique case (aluop_e'(op_i))
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_SLT:  res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            OP_SLTU: res_o = {{(XLEN-1){1'b0}}, (a_i < b_i)};
            OP_EQ:   res_o = {{(XLEN-1){1'b0}}, (a_i == b_i)};
            OP_NE:   res_o = {{(XLEN-1){1'b0}}, (a_i != b_i)};
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            default: res_o = '0;
        endcase
    end

    AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {3'd2, 3'd3, 3'd4, 3'd5}) |-> (res_o[XLEN-1:1] == '0)); // R7
endmodule

// File: rtl/sbus_immgen.sv
module sbus_immgen
    import sbus_pkg::*;
(
    input  logic [31:0]     ir_i,
    input  logic [1:0]      fmt_i,
    output logic [XLEN-1:0] imm_o
);
    logic sgn;
    assign sgn = ir_i[31];

    always_comb begin
        unique case (immfmt_e'(fmt_i))
            IMM_I: imm_o = {{(XLEN-12){sgn}}, ir_i[31:20]};
            IMM_J: imm_o = {{(XLEN-20){sgn}}, ir_i[19:12], ir_i[20], ir_i[30:21], 1'b0};
            IMM_B: imm_o = {{(XLEN-12){sgn}}, ir_i[7], ir_i[30:25], ir_i[11:8], 1'b0};
            IMM_S: imm_o = {{(XLEN-12){sgn}}, ir_i[31:25], ir_i[11:7]};
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  rsel_i,
    input  logic        reg_wr_i,
    input  logic        reg_drv_i,
    input  logic        a_ld_i,
    input  logic        b_ld_i,
    input  logic [2:0]  alu_op_i,
    input  logic        alu_drv_i,
    input  logic        mar_ld_i,
    input  logic        mem_drv_i,
    input  logic        mem_wr_i,
    input  logic        ir_ld_i,
    input  logic        imm_drv_i,
    input  logic [1:0]  imm_fmt_i,
    input  logic [31:0] mem_rdata_i,
    input  logic        mem_busy_i,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    output logic        mem_we_o,
    output logic        mem_re_o,
    output logic        busy_o,
    output logic [6:0]  opcode_o,
    output logic        cond_o,
    output logic [31:0] bus_o
);
    dp_state_t st_d, st_q;

    logic [IDXW-1:0] idx;
    logic [XLEN-1:0] reg_rd, alu_res, imm_val, bus;
    logic [3:0]      drv_vec;

    always_comb begin
        unique case (rsel_e'(rsel_i))
            RS_PC:   idx = IDXW'(PC_IDX);
            RS_RS1:  idx = IDXW'(st_q.ir[19:15]);
            RS_RS2:  idx = IDXW'(st_q.ir[24:20]);
            RS_RD:   idx = IDXW'(st_q.ir[11:7]);
            default: idx = '0;
        endcase
    end

    sbus_regram u_regram (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (idx),
        .we_i    (reg_wr_i),
        .wdata_i (bus),
        .rdata_o (reg_rd)
    );

    sbus_alu u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (alu_op_i),
        .a_i   (st_q.a),
        .b_i   (st_q.b),
        .res_o (alu_res)
    );

    sbus_immgen u_imm (
        .ir_i  (st_q.ir),
        .fmt_i (imm_fmt_i),
        .imm_o (imm_val)
    );

    // Gated OR of sources: zero when idle; exclusivity is checked below.
    assign drv_vec = {reg_drv_i, alu_drv_i, mem_drv_i, imm_drv_i};

    always_comb begin
        bus = '0;
        if (reg_drv_i) bus = bus | reg_rd;
        if (alu_drv_i) bus = bus | alu_res;
        if (mem_drv_i) bus = bus | mem_rdata_i;
        if (imm_drv_i) bus = bus | imm_val;
    end

    always_comb begin
        st_d = st_q;
        if (a_ld_i)   st_d.a   = bus;
        if (b_ld_i)   st_d.b   = bus;
        if (mar_ld_i) st_d.mar = bus;
        if (ir_ld_i)  st_d.ir  = bus[31:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_o       = bus;
    assign mem_addr_o  = st_q.mar;
    assign mem_wdata_o = bus;
    assign mem_we_o    = mem_wr_i;
    assign mem_re_o    = mem_drv_i;
    assign busy_o      = mem_busy_i;
    assign opcode_o    = st_q.ir[6:0];
    assign cond_o      = (alu_res != '0);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_vec)); // R2

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vec == 4'b0) |-> (bus_o == '0)); // R2

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !a_ld_i |=> $stable(st_q.a)); // R6

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !b_ld_i |=> $stable(st_q.b)); // R6

    AST_MAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mar_ld_i |=> (mem_addr_o == $past(bus_o))); // R9

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_ld_i |=> $stable(opcode_o)); // R10
endmodule

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rsel_i = '0;
    logic        reg_wr_i = 0, reg_drv_i = 0, a_ld_i = 0, b_ld_i = 0;
    logic [2:0]  alu_op_i = '0;
    logic        alu_drv_i = 0, mar_ld_i = 0, mem_drv_i = 0, mem_wr_i = 0;
    logic        ir_ld_i = 0, imm_drv_i = 0;
    logic [1:0]  imm_fmt_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_busy_i = 0;
    logic [31:0] mem_addr_o, mem_wdata_o, bus_o;
    logic        mem_we_o, mem_re_o, busy_o, cond_o;
    logic [6:0]  opcode_o;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sbus_datapath u0 (
        .clk(clk), .rst_n(rst_n), .rsel_i(rsel_i), .reg_wr_i(reg_wr_i),
        .reg_drv_i(reg_drv_i), .a_ld_i(a_ld_i), .b_ld_i(b_ld_i),
        .alu_op_i(alu_op_i), .alu_drv_i(alu_drv_i), .mar_ld_i(mar_ld_i),
        .mem_drv_i(mem_drv_i), .mem_wr_i(mem_wr_i), .ir_ld_i(ir_ld_i),
        .imm_drv_i(imm_drv_i), .imm_fmt_i(imm_fmt_i), .mem_rdata_i(mem_rdata_i),
        .mem_busy_i(mem_busy_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .busy_o(busy_o),
        .opcode_o(opcode_o), .cond_o(cond_o), .bus_o(bus_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rsel_i = '0; reg_wr_i = 0; reg_drv_i = 0; a_ld_i = 0; b_ld_i = 0;
        alu_op_i = '0; alu_drv_i = 0; mar_ld_i = 0; mem_drv_i = 0; mem_wr_i = 0;
        ir_ld_i = 0; imm_drv_i = 0; imm_fmt_i = '0; mem_rdata_i = '0;
    endtask

    // apply current controls across one rising edge, return at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    function automatic logic [31:0] mk_ir(input logic [4:0] rd, input logic [4:0] rs1,
                                          input logic [4:0] rs2);
        return {7'b0, rs2, rs1, 3'b0, rd, 7'h33};
    endfunction

    task automatic load_ir(input logic [31:0] w);
        mem_rdata_i = w; mem_drv_i = 1; ir_ld_i = 1;
        step();
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] v);
        mem_rdata_i = v; mem_drv_i = 1; rsel_i = sel; reg_wr_i = 1;
        step();
    endtask

    task automatic rd_reg(input logic [1:0] sel, input string req, input logic [31:0] exp);
        rsel_i = sel; reg_drv_i = 1; #1;
        chk(req, bus_o, exp);
        idle(); #1;
    endtask

    task automatic t_reset();
        chk("R1 mar", mem_addr_o, 32'h0);
        chk("R1 opcode", {25'b0, opcode_o}, 32'h0);
        chk("R2 idle bus", bus_o, 32'h0);
        alu_op_i = 3'd0; alu_drv_i = 1; #1;
        chk("R1 A+B", bus_o, 32'h0);
        idle(); #1;
    endtask

    task automatic t_regs();
        load_ir(mk_ir(5'd5, 5'd5, 5'd6));
        chk("R10 opcode", {25'b0, opcode_o}, 32'h33);
        wr_reg(2'd3, 32'h1234_5678);
        rd_reg(2'd1, "R3 rs1 after rd write", 32'h1234_5678);
        wr_reg(2'd2, 32'hCAFE_0006);
        rd_reg(2'd2, "R3 rs2", 32'hCAFE_0006);
        rd_reg(2'd1, "R3 rs1 unaffected", 32'h1234_5678);
        wr_reg(2'd0, 32'h0000_0100);
        load_ir(mk_ir(5'd31, 5'd0, 5'd0));
        wr_reg(2'd3, 32'hAAAA_5555);
        rd_reg(2'd0, "R5 pc after x31 write", 32'h0000_0100);
        wr_reg(2'd0, 32'h0000_0200);
        rd_reg(2'd3, "R5 x31 after pc write", 32'hAAAA_5555);
        rd_reg(2'd0, "R5 pc", 32'h0000_0200);
    endtask

    task automatic t_x0();
        load_ir(mk_ir(5'd0, 5'd0, 5'd0));
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, "R4 x0 read", 32'h0);
        rd_reg(2'd1, "R4 x0 via rs1", 32'h0);
    endtask

    task automatic set_ab(input logic [31:0] a, input logic [31:0] b);
        mem_rdata_i = a; mem_drv_i = 1; a_ld_i = 1; step();
        mem_rdata_i = b; mem_drv_i = 1; b_ld_i = 1; step();
    endtask

    task automatic alu_try(input logic [2:0] op, input logic [31:0] exp);
        alu_op_i = op; #1;
        chk("R8 cond", {31'b0, cond_o}, {31'b0, exp != 0});
        alu_drv_i = 1; #1;
        chk($sformatf("R7 op%0d", op), bus_o, exp);
        idle(); #1;
    endtask

    task automatic t_alu();
        logic [31:0] a, b;
        a = 32'hFFFF_FFFB; b = 32'h3;
        set_ab(a, b);
        alu_try(3'd0, a + b);
        alu_try(3'd1, a - b);
        alu_try(3'd2, 32'd1);
        alu_try(3'd3, 32'd0);
        alu_try(3'd4, 32'd0);
        alu_try(3'd5, 32'd1);
        alu_try(3'd6, a & b);
        alu_try(3'd7, a | b);
        // hold: bus activity without load strobes must not change A/B (R6)
        mem_rdata_i = 32'h7777_7777; mem_drv_i = 1; step();
        alu_try(3'd1, a - b);
        set_ab(32'h55, 32'h55);
        alu_try(3'd4, 32'd1);
        alu_try(3'd5, 32'd0);
        alu_try(3'd1, 32'd0);
    endtask

    task automatic t_route();
        load_ir(mk_ir(5'd9, 5'd5, 5'd6));
        // x5 = 0x12345678, x6 = 0xCAFE0006 from t_regs
        rsel_i = 2'd1; reg_drv_i = 1; a_ld_i = 1; step();
        rsel_i = 2'd2; reg_drv_i = 1; b_ld_i = 1; step();
        alu_op_i = 3'd0; alu_drv_i = 1; rsel_i = 2'd3; reg_wr_i = 1; step();
        rd_reg(2'd3, "R12 writeback", 32'h1234_5678 + 32'hCAFE_0006);
    endtask

    task automatic t_mem();
        mem_rdata_i = 32'h0000_0040; mem_drv_i = 1; mar_ld_i = 1; #1;
        chk("R9 re", {31'b0, mem_re_o}, 32'd1);
        step();
        chk("R9 addr", mem_addr_o, 32'h40);
        rsel_i = 2'd0; reg_drv_i = 1; mem_wr_i = 1; mem_busy_i = 1; #1;
        chk("R9 we", {31'b0, mem_we_o}, 32'd1);
        chk("R9 wdata", mem_wdata_o, 32'h0000_0200);
        chk("R9 busy", {31'b0, busy_o}, 32'd1);
        step();
        mem_busy_i = 0; #1;
        chk("R9 busy low", {31'b0, busy_o}, 32'd0);
        chk("R9 addr hold", mem_addr_o, 32'h40);
    endtask

    task automatic t_imm();
        logic [31:0] w;
        w = 32'b1010_1101_0110_1001_1100_1011_0110_0011;
        load_ir(w);
        chk("R10 opcode2", {25'b0, opcode_o}, {25'b0, w[6:0]});
        imm_drv_i = 1;
        imm_fmt_i = 2'd0; #1;
        chk("R11 I", bus_o, {{20{w[31]}}, w[31:20]});
        imm_fmt_i = 2'd1; #1;
        chk("R11 J", bus_o, {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0});
        imm_fmt_i = 2'd2; #1;
        chk("R11 B", bus_o, {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0});
        imm_fmt_i = 2'd3; #1;
        chk("R11 S", bus_o, {{20{w[31]}}, w[31:25], w[11:7]});
        idle(); #1;
    endtask

    initial begin
        fork
            begin
                idle();
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                #1;
                t_reset();
                t_regs();
                t_x0();
                t_alu();
                t_route();
                t_mem();
                t_imm();
            end
            begin
                repeat (5000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule